// File: doc/BRIEF.md
# Synthesizer Powerdown Sequencer

This block decides when a PLL frequency synthesizer is powered down and when it runs. It watches a chip-enable input, two bits of a serially loaded control word (a powerdown request and a mode select), the strobe that transfers that word into its holding register, and a pulse that marks each charge-pump event. From these it drives the powerdown controls of the rest of the synthesizer: a load-state force for each divider and timeout counter, a tri-state enable for the charge pump, a lock-detector reset, an input-bias disable and an oscillator-buffer disable.

Entry into powerdown can be immediate, or it can be held back until the next charge-pump event so that the loop is not disturbed in the middle of a correction. Leaving powerdown is always immediate once the strobe loads a cleared request bit. A low chip-enable overrides both register bits and powers the device down in the same cycle. The control register itself is outside this block and keeps loading during powerdown.

Top module: `pdseq_ctrl`

## Requirements
- R1: While chip_en is low, every powerdown output (pwr_down, cp_tristate, lock_rst, bias_off, osc_buf_off, all bits of ctr_load) is 1 in that same cycle, whatever the register bits and internal state hold.
- R2: After reset the block is powered down, and it stays so until a strobe (ld_stb = 1) loads pd_bit = 0 while chip_en is high.
- R3: A strobe that loads pd_bit = 1 when the last loaded value was 0, with mode_bit = 0, powers the device down from the next clock cycle on.
- R4: The same load with mode_bit = 1 leaves the device running; powerdown begins in the cycle after the first cp_evt pulse that arrives in a later cycle without a strobe. A cp_evt coinciding with any strobe is not counted.
- R5: mode_bit is sampled only on the strobe where pd_bit goes from 0 to 1; a further strobe with pd_bit = 1 and either mode value changes nothing, pending or not.
- R6: A strobe loading pd_bit = 0 returns the device to running from the next cycle, both from powerdown and from a waiting synchronous request, which is then cancelled.
- R7: All powerdown outputs switch together; ctr_load is always either all zeros or all ones.
- R8: Changes of pd_bit or mode_bit in cycles without a strobe have no effect on the outputs.
- R9: A cp_evt pulse while running with nothing pending, or while powered down, has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chip_en | input | 1 | Chip-enable; low forces powerdown |
| ld_stb | input | 1 | One-cycle strobe that loads pd_bit and mode_bit |
| pd_bit | input | 1 | Powerdown request from the control word (1 = down) |
| mode_bit | input | 1 | Entry mode (1 = wait for charge-pump event, 0 = immediate) |
| cp_evt | input | 1 | One-cycle pulse per charge-pump event |
| ctr_load | output | NUM_CTRS | Forces each counter to its load state |
| cp_tristate | output | 1 | Puts the charge pump in high impedance |
| lock_rst | output | 1 | Resets the lock detector |
| bias_off | output | 1 | Removes bias from the RF input |
| osc_buf_off | output | 1 | Disables the reference oscillator buffer |
| pwr_down | output | 1 | Device is powered down |

## Verification
A wrong sequencer state shows at the ports one cycle after the strobe or event that should have moved it: a stale pending request appears as a late or missing powerdown after a charge-pump pulse, and a lost cancel appears as a spurious powerdown at the next event. A wrongly latched mode shows as powerdown arriving one cycle after the strobe instead of after an event, or the reverse. Chip-enable faults show in the same cycle, since that path has no register.

// File: rtl/pdseq_pkg.sv
package pdseq_pkg;

  typedef enum logic [1:0] {
    PS_ACTIVE  = 2'd0,
    PS_PENDING = 2'd1,
    PS_DOWN    = 2'd2
  } pd_state_e;

  // Next sequencer state; the cancel/power-up request has highest priority.
  function automatic pd_state_e pd_next(
    input pd_state_e cur,
    input logic      want_up,
    input logic      want_async,
    input logic      want_sync,
    input logic      cp_fire
  );
    pd_state_e n;
    n = cur;
    if (want_up)                          n = PS_ACTIVE;
    else if (want_async)                  n = PS_DOWN;
    else if (want_sync)                   n = PS_PENDING;
    else if (cur == PS_PENDING && cp_fire) n = PS_DOWN;
    return n;
  endfunction

  // Effective powerdown: chip-enable low always wins.
  function automatic logic pd_effective(input logic ce, input pd_state_e st);
    return (!ce) || (st == PS_DOWN);
  endfunction

endpackage

// File: rtl/pdseq_req_decode.sv
module pdseq_req_decode (
  input  logic clk,
  input  logic rst_n,
  input  logic ld_stb,
  input  logic pd_bit,
  input  logic mode_bit,
  output logic req_up,
  output logic req_async,
  output logic req_sync
);
  logic pd_q;
  logic pd_rise;

  // Shadow of the last loaded request bit; reset matches the powered-down start.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pd_q <= 1'b1;
    else if (ld_stb) pd_q <= pd_bit;
  end

  assign pd_rise   = ld_stb && pd_bit && !pd_q;
  assign req_up    = ld_stb && !pd_bit;
  assign req_async = pd_rise && !mode_bit;
  assign req_sync  = pd_rise && mode_bit;
endmodule

// File: rtl/pdseq_fsm.sv
module pdseq_fsm
  import pdseq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      ld_stb,
  input  logic      cp_evt,
  input  logic      req_up,
  input  logic      req_async,
  input  logic      req_sync,
  output logic      cp_fire,
  output pd_state_e state
);
  pd_state_e state_d;

  // An event landing together with any load is not counted.
  assign cp_fire = cp_evt && !ld_stb;

  always_comb state_d = pd_next(state, req_up, req_async, req_sync, cp_fire);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PS_DOWN;
    else        state <= state_d;
  end
endmodule

// File: rtl/pdseq_out_drv.sv
module pdseq_out_drv
  import pdseq_pkg::*;
#(
  parameter int NUM_CTRS       = 3,
  parameter int CE_SYNC_STAGES = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chip_en,
  input  pd_state_e           state,
  output logic                ce_eff,
  output logic                pd_any,
  output logic [NUM_CTRS-1:0] ctr_load,
  output logic                cp_tristate,
  output logic                lock_rst,
  output logic                bias_off,
  output logic                osc_buf_off,
  output logic                pwr_down
);
  generate
    if (CE_SYNC_STAGES == 0) begin : g_ce_direct
      assign ce_eff = chip_en;
    end else begin : g_ce_sync
      logic [CE_SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[CE_SYNC_STAGES-2+1-1:0], chip_en} >> 0;
      end
      assign ce_eff = sync_q[CE_SYNC_STAGES-1];
    end
  endgenerate

  assign pd_any = pd_effective(ce_eff, state);

  generate
    for (genvar i = 0; i < NUM_CTRS; i++) begin : g_ctr
      assign ctr_load[i] = pd_any;
    end
  endgenerate

  assign cp_tristate = pd_any;
  assign lock_rst    = pd_any;
  assign bias_off    = pd_any;
  assign osc_buf_off = pd_any;
  assign pwr_down    = pd_any;
endmodule

// File: rtl/pdseq_ctrl.sv
module pdseq_ctrl
  import pdseq_pkg::*;
#(
  parameter int NUM_CTRS       = 3,
  parameter int CE_SYNC_STAGES = 0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                chip_en,
  input  logic                ld_stb,
  input  logic                pd_bit,
  input  logic                mode_bit,
  input  logic                cp_evt,
  output logic [NUM_CTRS-1:0] ctr_load,
  output logic                cp_tristate,
  output logic                lock_rst,
  output logic                bias_off,
  output logic                osc_buf_off,
  output logic                pwr_down
);
  logic      req_up, req_async, req_sync;
  logic      cp_fire;
  logic      ce_eff;
  logic      pd_any;
  pd_state_e seq_state;

  pdseq_req_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_stb   (ld_stb),
    .pd_bit   (pd_bit),
    .mode_bit (mode_bit),
    .req_up   (req_up),
    .req_async(req_async),
    .req_sync (req_sync)
  );

  pdseq_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .ld_stb   (ld_stb),
    .cp_evt   (cp_evt),
    .req_up   (req_up),
    .req_async(req_async),
    .req_sync (req_sync),
    .cp_fire  (cp_fire),
    .state    (seq_state)
  );

  pdseq_out_drv #(
    .NUM_CTRS      (NUM_CTRS),
    .CE_SYNC_STAGES(CE_SYNC_STAGES)
  ) u_drv (
    .clk        (clk),
    .rst_n      (rst_n),
    .chip_en    (chip_en),
    .state      (seq_state),
    .ce_eff     (ce_eff),
    .pd_any     (pd_any),
    .ctr_load   (ctr_load),
    .cp_tristate(cp_tristate),
    .lock_rst   (lock_rst),
    .bias_off   (bias_off),
    .osc_buf_off(osc_buf_off),
    .pwr_down   (pwr_down)
  );
endmodule

// File: rtl/pdseq_chk.sv
module pdseq_chk
  import pdseq_pkg::*;
#(
  parameter int NUM_CTRS = 3
) (
  input logic                clk,
  input logic                rst_n,
  input logic                ce_eff,
  input logic                ld_stb,
  input logic                pd_bit,
  input logic                mode_bit,
  input logic                cp_evt,
  input pd_state_e           state,
  input logic [NUM_CTRS-1:0] ctr_load,
  input logic                cp_tristate,
  input logic                lock_rst,
  input logic                pwr_down
);
  p_ce_low_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_eff |-> (pwr_down && cp_tristate && lock_rst && (&ctr_load)));

  p_async_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb && pd_bit && !mode_bit && state == PS_ACTIVE) |=> state == PS_DOWN);

  p_sync_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb && pd_bit && mode_bit && state == PS_ACTIVE) |=> state == PS_PENDING);

  p_sync_fire_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_PENDING && cp_evt && !ld_stb) |=> state == PS_DOWN);

  p_reload_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb && pd_bit && state == PS_PENDING) |=> state == PS_PENDING);

  p_power_up_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_stb && !pd_bit) |=> state == PS_ACTIVE);

  p_together_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(ctr_load) == 0 || $countones(ctr_load) == NUM_CTRS)
      && (cp_tristate == pwr_down) && (lock_rst == pwr_down));

  p_no_strobe_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_stb && !cp_evt) |=> $stable(state));

  p_idle_event_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld_stb && state != PS_PENDING) |=> $stable(state));
endmodule

bind pdseq_ctrl pdseq_chk #(.NUM_CTRS(NUM_CTRS)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ce_eff     (ce_eff),
  .ld_stb     (ld_stb),
  .pd_bit     (pd_bit),
  .mode_bit   (mode_bit),
  .cp_evt     (cp_evt),
  .state      (seq_state),
  .ctr_load   (ctr_load),
  .cp_tristate(cp_tristate),
  .lock_rst   (lock_rst),
  .pwr_down   (pwr_down)
);

// File: tb/pdseq_ctrl_tb.sv
module pdseq_ctrl_tb;
  localparam int NC = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chip_en = 1'b0, ld_stb = 1'b0, pd_bit = 1'b0, mode_bit = 1'b0, cp_evt = 1'b0;
  logic [NC-1:0] ctr_load;
  logic cp_tristate, lock_rst, bias_off, osc_buf_off, pwr_down;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // Bench model: 0 running, 1 waiting for event, 2 down
  int m_st = 2;
  bit m_pd = 1'b1;

  always #10 clk = ~clk;

  pdseq_ctrl #(.NUM_CTRS(NC)) u_dut (
    .clk(clk), .rst_n(rst_n), .chip_en(chip_en), .ld_stb(ld_stb),
    .pd_bit(pd_bit), .mode_bit(mode_bit), .cp_evt(cp_evt),
    .ctr_load(ctr_load), .cp_tristate(cp_tristate), .lock_rst(lock_rst),
    .bias_off(bias_off), .osc_buf_off(osc_buf_off), .pwr_down(pwr_down)
  );

  function automatic int model_next(int st, bit pdq, bit stb, bit pd, bit md, bit cp);
    if (stb) begin
      if (!pd) return 0;
      if (!pdq) return md ? 1 : 2;
      return st;
    end
    if (st == 1 && cp) return 2;
    return st;
  endfunction

  function automatic bit model_down(bit ce, int st);
    return !ce || (st == 2);
  endfunction

  task automatic check_outs(input string tag);
    bit e;
    logic [5:0] act, exp;
    e   = model_down(chip_en, m_st);
    act = {pwr_down, cp_tristate, lock_rst, bias_off, osc_buf_off, (&ctr_load) & (|ctr_load | 1'b0)};
    if (!(&ctr_load) && (|ctr_load)) act[0] = 1'bx;
    exp = {6{e}};
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: outputs act=%b exp=%b ctr_load=%b", tag, act, exp, ctr_load);
    end
  endtask

  // Drive one cycle of inputs, advance the model at the edge, check after it.
  task automatic cyc(input bit ce, input bit stb, input bit pd, input bit md,
                     input bit cp, input string tag);
    @(negedge clk);
    chip_en = ce; ld_stb = stb; pd_bit = pd; mode_bit = md; cp_evt = cp;
    #1 check_outs({tag, " pre-edge"});
    m_st = model_next(m_st, m_pd, stb, pd, md, cp);
    if (stb) m_pd = pd;
    @(posedge clk);
    #5 check_outs(tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: act=timeout exp=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R2: powered down after reset, chip_en high, no strobe yet
    cyc(1, 0, 0, 0, 0, "R2 reset state");
    cyc(1, 0, 0, 1, 1, "R2 R8 no strobe keeps down");
    cyc(1, 1, 1, 0, 0, "R2 reload 1 stays down");
    cyc(1, 1, 0, 0, 0, "R2 R6 power-up load 0");
    cyc(1, 0, 0, 0, 1, "R9 event while running");
    cyc(0, 0, 0, 0, 0, "R1 chip_en low");
    cyc(1, 0, 1, 0, 0, "R8 pd change without strobe");
    cyc(1, 1, 1, 0, 0, "R3 async entry");
    cyc(1, 0, 0, 0, 1, "R9 event while down");
    cyc(1, 1, 0, 0, 0, "R6 up from async");
    cyc(1, 1, 1, 1, 1, "R4 sync load with coincident event");
    cyc(1, 0, 0, 0, 0, "R4 waiting");
    cyc(1, 1, 1, 0, 0, "R5 reload mode 0 while pending");
    cyc(0, 0, 1, 0, 0, "R1 chip_en low while pending");
    cyc(1, 0, 1, 0, 1, "R4 event fires");
    cyc(1, 0, 1, 0, 0, "R4 R7 down after event");
    cyc(1, 1, 0, 1, 0, "R6 up from sync");
    cyc(1, 1, 1, 1, 0, "R6 sync load");
    cyc(1, 1, 0, 0, 1, "R6 cancel with event");
    cyc(1, 0, 0, 0, 1, "R6 cancelled stays up");
    for (int i = 0; i < 3000; i++) begin
      bit ce, stb, pd, md, cp;
      ce  = ($urandom_range(0, 9) != 0);
      stb = ($urandom_range(0, 3) == 0);
      pd  = $urandom_range(0, 1);
      md  = $urandom_range(0, 1);
      cp  = ($urandom_range(0, 3) == 0);
      cyc(ce, stb, pd, md, cp, "R7 random");
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule